// File: doc/BRIEF.md
# Protected Register File with Access Checks

This block holds the architectural registers of a small 32-bit processor core and polices every access made to them. Operands are named by a 5-bit register number. Two read ports return data in the same cycle the number is presented, and one write port commits on the rising clock edge. A mode input selects user or kernel privilege. The block also takes a strobe that marks an attempted write to the program counter, which is held outside this block.

The number space is split into classes, and each class has its own rules. The low sixteen numbers are general-purpose registers. The next four are special registers that are freely readable and writable. Two numbers are reserved for kernel use. One number is a constant zero, one is a placeholder that must never be used as an operand, and the top eight numbers are reserved. In any cycle the block raises an illegal-instruction flag and a protection-fault flag from the combined accesses of that cycle. A cycle that raises either flag leaves the register contents untouched. The surrounding pipeline decides how to vector the fault.

Top module: `prf_regfile`

## Requirements
- R1: Synchronous active-high reset clears every storable register (numbers 0x00 to 0x15) to zero.
- R2: A fault-free write to a number in 0x00 to 0x13, or to 0x14 or 0x15 in kernel mode, can be read back on either read port from the following cycle.
- R3: A read of the number that is being written in the same cycle returns the value held before that write.
- R4: While user_mode is 1, reading or writing number 0x14 or 0x15 raises protect_flt. In kernel mode (user_mode 0) these numbers behave like ordinary registers.
- R5: Number 0x16 always reads as zero. A write to it is dropped and raises no flag.
- R6: Using number 0x17 on an enabled read port or on the write port raises illegal_flt.
- R7: Using any number from 0x18 to 0x1F on an enabled read port or on the write port raises illegal_flt.
- R8: Asserting pc_wr_try raises protect_flt.
- R9: In a cycle in which illegal_flt or protect_flt is high, no register changes, whichever access caused the flag.
- R10: A read port that is disabled, or whose own access faults, returns zero. A disabled port raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| user_mode | input | 1 | 1 selects user privilege, 0 selects kernel privilege |
| rd_a_en | input | 1 | Read port A is in use |
| rd_a_num | input | 5 | Register number for read port A |
| rd_a_data | output | DATA_W | Read port A data, combinational |
| rd_b_en | input | 1 | Read port B is in use |
| rd_b_num | input | 5 | Register number for read port B |
| rd_b_data | output | DATA_W | Read port B data, combinational |
| wr_en | input | 1 | Write port is in use |
| wr_num | input | 5 | Register number for the write |
| wr_data | input | DATA_W | Write data |
| pc_wr_try | input | 1 | Marks an attempted write to the program counter |
| illegal_flt | output | 1 | Illegal-instruction condition in this cycle |
| protect_flt | output | 1 | Protection-fault condition in this cycle |

## Verification
A stored word that is wrong, such as a write that leaked through in a faulting cycle or a missed reset, stays hidden until that number is read again. It then appears as wrong data on a read port in the very cycle of that read, with no extra latency. The flags are decoded from the current cycle's inputs alone, so a misclassified number shows up on illegal_flt or protect_flt in the same cycle it is presented. Because of this, every check follows a write with a read of the same number on the next cycle, and also reads back each number that a faulting cycle could have corrupted.

// File: rtl/prf_pkg.sv
package prf_pkg;

  localparam int NUM_W = 5;

  // Boundaries of the register number classes
  localparam logic [NUM_W-1:0] NUM_SPEC_LO = 5'h10;
  localparam logic [NUM_W-1:0] NUM_PRIV_LO = 5'h14;
  localparam logic [NUM_W-1:0] NUM_CONST0  = 5'h16;
  localparam logic [NUM_W-1:0] NUM_HOLE    = 5'h17;
  localparam logic [NUM_W-1:0] NUM_RSVD_LO = 5'h18;

  // Entries that really hold state: everything below the constant-zero number
  localparam int STORE_DEPTH = int'(NUM_CONST0);

  typedef enum logic [2:0] {
    CLS_GEN,
    CLS_SPEC,
    CLS_PRIV,
    CLS_CONST0,
    CLS_HOLE,
    CLS_RSVD
  } reg_cls_e;

endpackage

// File: rtl/prf_classify.sv
module prf_classify
  import prf_pkg::*;
(
  input  logic [NUM_W-1:0] num,
  output reg_cls_e         cls
);

  always_comb begin
    if (num >= NUM_RSVD_LO)      cls = CLS_RSVD;
    else if (num == NUM_HOLE)    cls = CLS_HOLE;
    else if (num == NUM_CONST0)  cls = CLS_CONST0;
    else if (num >= NUM_PRIV_LO) cls = CLS_PRIV;
    else if (num >= NUM_SPEC_LO) cls = CLS_SPEC;
    else                         cls = CLS_GEN;
  end

endmodule

// File: rtl/prf_access_check.sv
module prf_access_check
  import prf_pkg::*;
(
  input  logic     en,
  input  reg_cls_e cls,
  input  logic     user_mode,
  output logic     ok,       // access touches real storage and is allowed
  output logic     illegal,
  output logic     protect
);

  always_comb begin
    ok      = 1'b0;
    illegal = 1'b0;
    protect = 1'b0;
    if (en) begin
      unique case (cls)
        CLS_GEN, CLS_SPEC: ok = 1'b1;
        CLS_PRIV: begin
          if (user_mode) protect = 1'b1;
          else           ok      = 1'b1;
        end
        CLS_CONST0: ok = 1'b0;          // reads give zero, writes vanish
        CLS_HOLE, CLS_RSVD: illegal = 1'b1;
        default: illegal = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/prf_storage.sv
module prf_storage #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 22,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DEPTH-1:0][DATA_W-1:0] mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem <= '0;
    end else if (we && waddr <= LAST) begin
      mem[waddr] <= wdata;
    end
  end

  // Asynchronous reads see the contents before the pending edge
  always_comb begin
    rdata_a = (raddr_a <= LAST) ? mem[raddr_a] : '0;
    rdata_b = (raddr_b <= LAST) ? mem[raddr_b] : '0;
  end

endmodule

// File: rtl/prf_regfile.sv
module prf_regfile
  import prf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              user_mode,
  input  logic              rd_a_en,
  input  logic [4:0]        rd_a_num,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic              rd_b_en,
  input  logic [4:0]        rd_b_num,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [4:0]        wr_num,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pc_wr_try,
  output logic              illegal_flt,
  output logic              protect_flt
);

  // Access slots: 0 = read A, 1 = read B, 2 = write
  localparam int N_ACC = 3;
  localparam int IDX_WR = N_ACC - 1;

  logic [N_ACC-1:0]            acc_en;
  logic [N_ACC-1:0][NUM_W-1:0] acc_num;
  logic [N_ACC-1:0]            acc_ok;
  logic [N_ACC-1:0]            acc_ill;
  logic [N_ACC-1:0]            acc_prot;
  reg_cls_e                    acc_cls [N_ACC];

  assign acc_en  = {wr_en, rd_b_en, rd_a_en};
  assign acc_num = {wr_num, rd_b_num, rd_a_num};

  for (genvar g = 0; g < N_ACC; g++) begin : g_acc
    prf_classify u_cls (
      .num (acc_num[g]),
      .cls (acc_cls[g])
    );
    prf_access_check u_chk (
      .en        (acc_en[g]),
      .cls       (acc_cls[g]),
      .user_mode (user_mode),
      .ok        (acc_ok[g]),
      .illegal   (acc_ill[g]),
      .protect   (acc_prot[g])
    );
  end

  logic any_fault;
  logic commit;
  logic [DATA_W-1:0] raw_a, raw_b;

  always_comb begin
    illegal_flt = |acc_ill;
    protect_flt = (|acc_prot) | pc_wr_try;
    any_fault   = illegal_flt | protect_flt;
    commit      = acc_ok[IDX_WR] & ~any_fault;
  end

  prf_storage #(
    .DATA_W (DATA_W),
    .DEPTH  (STORE_DEPTH),
    .ADDR_W (NUM_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (commit),
    .waddr   (wr_num),
    .wdata   (wr_data),
    .raddr_a (rd_a_num),
    .raddr_b (rd_b_num),
    .rdata_a (raw_a),
    .rdata_b (raw_b)
  );

  always_comb begin
    rd_a_data = acc_ok[0] ? raw_a : '0;
    rd_b_data = acc_ok[1] ? raw_b : '0;
  end

endmodule

// File: rtl/prf_checker.sv
module prf_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              user_mode,
  input logic              rd_a_en,
  input logic [4:0]        rd_a_num,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              rd_b_en,
  input logic [4:0]        rd_b_num,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [4:0]        wr_num,
  input logic [DATA_W-1:0] wr_data,
  input logic              pc_wr_try,
  input logic              illegal_flt,
  input logic              protect_flt
);

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && rd_a_en && rd_a_num < 5'h16) |-> rd_a_data == '0); // R1

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && !$past(illegal_flt) && !$past(protect_flt)
     && $past(wr_num) < 5'h14 && rd_a_en && rd_a_num == $past(wr_num))
    |-> rd_a_data == $past(wr_data)); // R2

  AST_PRIV_USER_PROTECT: assert property (@(posedge clk) disable iff (rst)
    (user_mode && rd_b_en && (rd_b_num == 5'h14 || rd_b_num == 5'h15))
    |-> protect_flt); // R4

  AST_CONST_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_b_en && rd_b_num == 5'h16) |-> rd_b_data == '0); // R5

  AST_HOLE_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (rd_a_en && rd_a_num == 5'h17) |-> illegal_flt); // R6

  AST_RSVD_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_num >= 5'h18) |-> illegal_flt); // R7

  AST_PC_WRITE_PROTECT: assert property (@(posedge clk) disable iff (rst)
    pc_wr_try |-> protect_flt); // R8

  AST_FAULT_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(illegal_flt) || $past(protect_flt)) && $past(wr_en)
     && $past(rd_a_en) && rd_a_en && rd_a_num == $past(rd_a_num)
     && rd_a_num == $past(wr_num) && $stable(user_mode))
    |-> rd_a_data == $past(rd_a_data)); // R9

  AST_DISABLED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_a_en |-> rd_a_data == '0); // R10

endmodule

bind prf_regfile prf_checker #(.DATA_W(DATA_W)) u_prf_checker (.*);

// File: tb/test_prf_regfile.sv
`timescale 1ns/1ps
module test_prf_regfile;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          user_mode = 1'b0;
  logic          rd_a_en = 1'b0, rd_b_en = 1'b0, wr_en = 1'b0, pc_wr_try = 1'b0;
  logic [4:0]    rd_a_num = '0, rd_b_num = '0, wr_num = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_a_data, rd_b_data;
  logic          illegal_flt, protect_flt;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  prf_regfile #(.DATA_W(DW)) i_prf_regfile (
    .clk(clk), .rst(rst), .user_mode(user_mode),
    .rd_a_en(rd_a_en), .rd_a_num(rd_a_num), .rd_a_data(rd_a_data),
    .rd_b_en(rd_b_en), .rd_b_num(rd_b_num), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
    .pc_wr_try(pc_wr_try), .illegal_flt(illegal_flt), .protect_flt(protect_flt)
  );

  typedef struct packed {
    logic          usr;
    logic          we;
    logic [4:0]    wn;
    logic [DW-1:0] wd;
    logic [4:0]    ra;
    logic [4:0]    rb;
    logic [DW-1:0] ea;
    logic [DW-1:0] eb;
    logic          eill;
    logic          eprot;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b1, 5'h03, 32'h1111_2222, 5'h03, 5'h03, 32'h0,         32'h0,         1'b0, 1'b0}, // R3
    '{1'b0, 1'b0, 5'h00, 32'h0,         5'h03, 5'h00, 32'h1111_2222, 32'h0,         1'b0, 1'b0}, // R2
    '{1'b0, 1'b1, 5'h10, 32'hA5A5_0001, 5'h10, 5'h03, 32'h0,         32'h1111_2222, 1'b0, 1'b0}, // R3
    '{1'b0, 1'b1, 5'h13, 32'hDEAD_BEEF, 5'h10, 5'h13, 32'hA5A5_0001, 32'h0,         1'b0, 1'b0}, // R2
    '{1'b0, 1'b1, 5'h14, 32'h0000_0100, 5'h13, 5'h14, 32'hDEAD_BEEF, 32'h0,         1'b0, 1'b0}, // R4 kernel
    '{1'b1, 1'b0, 5'h00, 32'h0,         5'h14, 5'h03, 32'h0,         32'h1111_2222, 1'b0, 1'b1}, // R4 R10
    '{1'b1, 1'b1, 5'h15, 32'h0000_0005, 5'h03, 5'h10, 32'h1111_2222, 32'hA5A5_0001, 1'b0, 1'b1}, // R4
    '{1'b0, 1'b0, 5'h00, 32'h0,         5'h15, 5'h14, 32'h0,         32'h0000_0100, 1'b0, 1'b0}, // R9
    '{1'b0, 1'b1, 5'h16, 32'hFFFF_FFFF, 5'h16, 5'h16, 32'h0,         32'h0,         1'b0, 1'b0}, // R5
    '{1'b0, 1'b0, 5'h00, 32'h0,         5'h16, 5'h17, 32'h0,         32'h0,         1'b1, 1'b0}, // R5 R6
    '{1'b0, 1'b1, 5'h17, 32'h0000_0007, 5'h03, 5'h03, 32'h1111_2222, 32'h1111_2222, 1'b1, 1'b0}, // R6
    '{1'b0, 1'b1, 5'h03, 32'h0000_0005, 5'h18, 5'h03, 32'h0,         32'h1111_2222, 1'b1, 1'b0}, // R7
    '{1'b0, 1'b0, 5'h00, 32'h0,         5'h03, 5'h1F, 32'h1111_2222, 32'h0,         1'b1, 1'b0}, // R9 R7
    '{1'b0, 1'b1, 5'h0F, 32'h1234_5678, 5'h0F, 5'h00, 32'h0,         32'h0,         1'b0, 1'b0}, // R3
    '{1'b0, 1'b0, 5'h00, 32'h0,         5'h0F, 5'h12, 32'h1234_5678, 32'h0,         1'b0, 1'b0}  // R2
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic usr, input logic we, input logic [4:0] wn,
                       input logic [DW-1:0] wd, input logic ae, input logic [4:0] ra,
                       input logic be, input logic [4:0] rb, input logic pc);
    @(negedge clk);
    user_mode = usr; wr_en = we; wr_num = wn; wr_data = wd;
    rd_a_en = ae; rd_a_num = ra; rd_b_en = be; rd_b_num = rb; pc_wr_try = pc;
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: every storable number reads zero after reset, no flags
    for (int n = 0; n < 22; n++) begin
      drive(1'b0, 1'b0, 5'h00, '0, 1'b1, 5'(n), 1'b1, 5'(n), 1'b0);
      check("R1 read A", rd_a_data, '0);
      check("R1 read B", rd_b_data, '0);
      check("R1 flags", {30'b0, illegal_flt, protect_flt}, '0);
    end

    // Table walk
    for (int i = 0; i < NV; i++) begin
      drive(VT[i].usr, VT[i].we, VT[i].wn, VT[i].wd, 1'b1, VT[i].ra, 1'b1, VT[i].rb, 1'b0);
      check($sformatf("R2/R3/R4/R5/R9/R10 row %0d port A", i), rd_a_data, VT[i].ea);
      check($sformatf("R2/R3/R4/R5/R9/R10 row %0d port B", i), rd_b_data, VT[i].eb);
      check($sformatf("R4/R6/R7 row %0d illegal", i), {31'b0, illegal_flt}, {31'b0, VT[i].eill});
      check($sformatf("R4/R8 row %0d protect", i), {31'b0, protect_flt}, {31'b0, VT[i].eprot});
    end

    // R8: program counter write attempt faults and suppresses a legal write (R9)
    drive(1'b0, 1'b1, 5'h05, 32'h0000_0077, 1'b0, 5'h00, 1'b0, 5'h00, 1'b1);
    check("R8 protect", {31'b0, protect_flt}, 32'h1);
    check("R8 illegal", {31'b0, illegal_flt}, 32'h0);
    drive(1'b0, 1'b0, 5'h00, '0, 1'b1, 5'h05, 1'b0, 5'h00, 1'b0);
    check("R9 r5 unchanged", rd_a_data, '0);

    // R2: same write without the strobe lands
    drive(1'b0, 1'b1, 5'h05, 32'h0000_0077, 1'b0, 5'h00, 1'b0, 5'h00, 1'b0);
    drive(1'b0, 1'b0, 5'h00, '0, 1'b0, 5'h00, 1'b1, 5'h05, 1'b0);
    check("R2 r5 readback", rd_b_data, 32'h0000_0077);

    // R10: disabled ports return zero and flag nothing, even on bad numbers
    drive(1'b1, 1'b0, 5'h00, '0, 1'b0, 5'h05, 1'b0, 5'h17, 1'b0);
    check("R10 disabled A", rd_a_data, '0);
    check("R10 disabled B", rd_b_data, '0);
    check("R10 no flags", {30'b0, illegal_flt, protect_flt}, '0);

    // R6: placeholder as write target with kernel mode
    drive(1'b0, 1'b1, 5'h17, 32'h1, 1'b0, 5'h00, 1'b0, 5'h00, 1'b0);
    check("R6 write illegal", {31'b0, illegal_flt}, 32'h1);

    // R1: reset again clears prior contents
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; rd_a_en = 1'b0; rd_b_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 1'b0, 5'h00, '0, 1'b1, 5'h03, 1'b1, 5'h05, 1'b0);
    check("R1 r3 cleared", rd_a_data, '0);
    check("R1 r5 cleared", rd_b_data, '0);
    drive(1'b0, 1'b0, 5'h00, '0, 1'b1, 5'h14, 1'b1, 5'h0F, 1'b0);
    check("R1 0x14 cleared", rd_a_data, '0);
    check("R1 r15 cleared", rd_b_data, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule